// File: doc/BRIEF.md
# Dual-Granularity Register RAM

This block is the operand store of one processing core: 512 words of 32 bits behind three read ports and one write port. All three read ports serve ordinary instruction operands, and each returns the addressed word one clock after the address is presented.

Read port A and the write port can also work on a whole aligned group of eight words (256 bits) in one access. This lets bulk data move between the core and a shared memory one group per clock instead of one word per clock. The storage is 64 rows of 256 bits, so a group is one row. A narrow access picks one 32-bit lane of the row using the low three address bits. A wide access uses only the upper six address bits.

Top module: `wide_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rd_a_data`, `rd_b_data`, `rd_c_data` and `rd_a_row` all become zero. They stay zero until an enabled read of the matching kind.
- R2: A narrow read (port enabled, and `rd_a_wide` low for port A) at address N updates that port's 32-bit data output on the next clock edge with word N. N is a 9-bit word address.
- R3: A narrow write (`wr_en` high, `wr_wide` low) stores `wr_data` into word `wr_addr` only. The other seven words of the same 8-word group keep their values.
- R4: A wide write (`wr_en` and `wr_wide` high) stores all eight words of group `wr_addr[8:3]`. Word k of the group (address group*8+k) takes `wr_row[32k+31:32k]`. `wr_data` and `wr_addr[2:0]` have no effect.
- R5: A wide read on port A (`rd_a_en` and `rd_a_wide` high) loads group `rd_a_addr[8:3]` into `rd_a_row` on the next edge, with word k at bits `[32k+31:32k]`. `rd_a_addr[2:0]` has no effect, and `rd_a_data` keeps its value.
- R6: A read port whose enable is low keeps its data outputs unchanged. A narrow read on port A leaves `rd_a_row` unchanged.
- R7: When a read and a write hit the same word or group at the same edge, the read returns the contents from before the write. This holds for narrow and for wide accesses. A read on the following edge returns the new contents.
- R8: The three read ports work independently in the same cycle. Two ports given the same address return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the read outputs |
| rd_a_en | input | 1 | Port A read enable |
| rd_a_wide | input | 1 | Port A access width: 1 = 8-word group, 0 = single word |
| rd_a_addr | input | 9 | Port A word address (bits [8:3] select the group) |
| rd_a_data | output | 32 | Port A narrow read data |
| rd_a_row | output | 256 | Port A wide read data, word k at bits [32k+31:32k] |
| rd_b_en | input | 1 | Port B read enable |
| rd_b_addr | input | 9 | Port B word address |
| rd_b_data | output | 32 | Port B read data |
| rd_c_en | input | 1 | Port C read enable |
| rd_c_addr | input | 9 | Port C word address |
| rd_c_data | output | 32 | Port C read data |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | Write width: 1 = 8-word group, 0 = single word |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 32 | Narrow write data |
| wr_row | input | 256 | Wide write data, word k at bits [32k+31:32k] |

## Verification
The bench sweeps every word and every group. It checks that lane order inside a row matches the word addresses: a design with swapped or mirrored lanes would return data from the wrong address in either mode. It writes single lanes into a group that was written wide, which catches a write mask that spills into other lanes. It gives wide accesses nonzero low address bits, which catches a design that lets those bits shift the group. Same-cycle collisions at both widths would show new data a cycle early if the design forwarded writes. Idle ports and crossed modes on port A are checked to hold, which catches output registers that update on the wrong enable.

// File: rtl/wide_regfile_pkg.sv
// Package wide_regfile_pkg
// Shared types for the dual-granularity register RAM.
// Assumes: the access width is a single-bit choice per access.
package wide_regfile_pkg;

    // Access width of a read or write on a dual-mode port
    typedef enum logic {
        ACC_NARROW = 1'b0,
        ACC_WIDE   = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/wide_regfile_lane_mask.sv
// Module wide_regfile_lane_mask
// Turns a write width and a lane index into a per-lane write-enable mask.
// A wide write enables every lane. A narrow write enables only the addressed lane.
// Assumes: LANES is a power of two.
module wide_regfile_lane_mask #(
    parameter int LANES  = 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              wide,
    input  logic [LANE_W-1:0] lane,
    output logic [LANES-1:0]  mask
);

    // One enable per lane: set for every lane when wide, else only on an index match
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign mask[l] = wide || (lane == LANE_W'(l));
    end

endmodule

// File: rtl/wide_regfile_array.sv
// Module wide_regfile_array
// Row-organised storage, ROWS rows of LANES words each.
// It has one lane-masked write port and three combinational row views.
// Reads are registered outside this module, so a read at the same edge as a write sees the old row.
// Assumes: ROWS is a power of two. The contents are not reset.
module wide_regfile_array #(
    parameter int WORD_W   = 32,
    parameter int LANES    = 8,
    parameter int ROWS     = 64,
    parameter int ROW_W    = $clog2(ROWS),
    parameter int ROW_BITS = WORD_W * LANES
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ROW_W-1:0]    wrow,
    input  logic [LANES-1:0]    lane_we,
    input  logic [ROW_BITS-1:0] wbus,
    input  logic [ROW_W-1:0]    rrow_a,
    input  logic [ROW_W-1:0]    rrow_b,
    input  logic [ROW_W-1:0]    rrow_c,
    output logic [ROW_BITS-1:0] row_a,
    output logic [ROW_BITS-1:0] row_b,
    output logic [ROW_BITS-1:0] row_c
);

    logic [ROW_BITS-1:0] mem [ROWS];

    // Write the enabled lanes of the selected row
    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l]) begin
                    mem[wrow][l*WORD_W +: WORD_W] <= wbus[l*WORD_W +: WORD_W];
                end
            end
        end
    end

    // Present the rows the three read ports address
    assign row_a = mem[rrow_a];
    assign row_b = mem[rrow_b];
    assign row_c = mem[rrow_c];

endmodule

// File: rtl/wide_regfile_rdport.sv
// Module wide_regfile_rdport
// Narrow read register: selects one word of a row (the column mux) and registers it.
// Assumes: en is already qualified for a narrow access. The output holds when en is low.
module wide_regfile_rdport #(
    parameter int WORD_W   = 32,
    parameter int LANES    = 8,
    parameter int LANE_W   = $clog2(LANES),
    parameter int ROW_BITS = WORD_W * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [LANE_W-1:0]   lane,
    input  logic [ROW_BITS-1:0] row_in,
    output logic [WORD_W-1:0]   word_q
);

    logic [WORD_W-1:0] word_sel;

    // Column select: pick the addressed word out of the row
    assign word_sel = row_in[lane*WORD_W +: WORD_W];

    // Register the selected word, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (en) begin
            word_q <= word_sel;
        end
    end

endmodule

// File: rtl/wide_regfile.sv
// Module wide_regfile
// Register RAM with three synchronous narrow read ports and one write port.
// Read port A and the write port can also move a whole row (one aligned word group) per access.
// Assumes: the address is {row, lane}. Only the read outputs are reset, not the storage.
module wide_regfile
    import wide_regfile_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int LANES    = 8,
    parameter int ROWS     = 64,
    parameter int ADDR_W   = $clog2(ROWS) + $clog2(LANES),
    parameter int ROW_BITS = WORD_W * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_a_en,
    input  logic                rd_a_wide,
    input  logic [ADDR_W-1:0]   rd_a_addr,
    output logic [WORD_W-1:0]   rd_a_data,
    output logic [ROW_BITS-1:0] rd_a_row,
    input  logic                rd_b_en,
    input  logic [ADDR_W-1:0]   rd_b_addr,
    output logic [WORD_W-1:0]   rd_b_data,
    input  logic                rd_c_en,
    input  logic [ADDR_W-1:0]   rd_c_addr,
    output logic [WORD_W-1:0]   rd_c_data,
    input  logic                wr_en,
    input  logic                wr_wide,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ROW_BITS-1:0] wr_row
);

    localparam int LANE_W = $clog2(LANES);
    localparam int ROW_W  = $clog2(ROWS);

    acc_mode_e           wr_mode;
    acc_mode_e           rd_a_mode;
    logic [LANES-1:0]    lane_we;
    logic [ROW_BITS-1:0] wbus;
    logic [ROW_BITS-1:0] row_a;
    logic [ROW_BITS-1:0] row_b;
    logic [ROW_BITS-1:0] row_c;
    logic                rd_a_narrow_en;
    logic                rd_a_wide_en;

    // Decode the access widths of the two dual-mode ports
    assign wr_mode        = acc_mode_e'(wr_wide);
    assign rd_a_mode      = acc_mode_e'(rd_a_wide);
    assign rd_a_narrow_en = rd_a_en && (rd_a_mode == ACC_NARROW);
    assign rd_a_wide_en   = rd_a_en && (rd_a_mode == ACC_WIDE);

    // Lane write enables from the write width and the low address bits
    wide_regfile_lane_mask #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_mask (
        .wide (wr_mode == ACC_WIDE),
        .lane (wr_addr[LANE_W-1:0]),
        .mask (lane_we)
    );

    // Write bus: the row data when wide, else the narrow word copied into every lane
    for (genvar l = 0; l < LANES; l++) begin : g_wbus
        assign wbus[l*WORD_W +: WORD_W] =
            (wr_mode == ACC_WIDE) ? wr_row[l*WORD_W +: WORD_W] : wr_data;
    end

    wide_regfile_array #(
        .WORD_W   (WORD_W),
        .LANES    (LANES),
        .ROWS     (ROWS),
        .ROW_W    (ROW_W),
        .ROW_BITS (ROW_BITS)
    ) u_array (
        .clk     (clk),
        .we      (wr_en),
        .wrow    (wr_addr[ADDR_W-1:LANE_W]),
        .lane_we (lane_we),
        .wbus    (wbus),
        .rrow_a  (rd_a_addr[ADDR_W-1:LANE_W]),
        .rrow_b  (rd_b_addr[ADDR_W-1:LANE_W]),
        .rrow_c  (rd_c_addr[ADDR_W-1:LANE_W]),
        .row_a   (row_a),
        .row_b   (row_b),
        .row_c   (row_c)
    );

    wide_regfile_rdport #(
        .WORD_W (WORD_W), .LANES (LANES), .LANE_W (LANE_W), .ROW_BITS (ROW_BITS)
    ) u_rd_a (
        .clk (clk), .rst_n (rst_n), .en (rd_a_narrow_en),
        .lane (rd_a_addr[LANE_W-1:0]), .row_in (row_a), .word_q (rd_a_data)
    );

    wide_regfile_rdport #(
        .WORD_W (WORD_W), .LANES (LANES), .LANE_W (LANE_W), .ROW_BITS (ROW_BITS)
    ) u_rd_b (
        .clk (clk), .rst_n (rst_n), .en (rd_b_en),
        .lane (rd_b_addr[LANE_W-1:0]), .row_in (row_b), .word_q (rd_b_data)
    );

    wide_regfile_rdport #(
        .WORD_W (WORD_W), .LANES (LANES), .LANE_W (LANE_W), .ROW_BITS (ROW_BITS)
    ) u_rd_c (
        .clk (clk), .rst_n (rst_n), .en (rd_c_en),
        .lane (rd_c_addr[LANE_W-1:0]), .row_in (row_c), .word_q (rd_c_data)
    );

    // Wide read register of port A: captures the whole row on a wide read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_a_row <= '0;
        end else if (rd_a_wide_en) begin
            rd_a_row <= row_a;
        end
    end

endmodule

// File: rtl/wide_regfile_checker.sv
// Module wide_regfile_checker
// Temporal checks on the ports of wide_regfile. It is attached by the bind at the end of this file.
// Assumes: it sees the same clock and synchronous active-low reset as the design.
module wide_regfile_checker #(
    parameter int WORD_W   = 32,
    parameter int LANES    = 8,
    parameter int ROWS     = 64,
    parameter int ADDR_W   = $clog2(ROWS) + $clog2(LANES),
    parameter int ROW_BITS = WORD_W * LANES
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_a_en,
    input logic                rd_a_wide,
    input logic [ADDR_W-1:0]   rd_a_addr,
    input logic [WORD_W-1:0]   rd_a_data,
    input logic [ROW_BITS-1:0] rd_a_row,
    input logic                rd_b_en,
    input logic [ADDR_W-1:0]   rd_b_addr,
    input logic [WORD_W-1:0]   rd_b_data,
    input logic                rd_c_en,
    input logic [ADDR_W-1:0]   rd_c_addr,
    input logic [WORD_W-1:0]   rd_c_data,
    input logic                wr_en,
    input logic                wr_wide,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [WORD_W-1:0]   wr_data,
    input logic [ROW_BITS-1:0] wr_row
);

    localparam int LANE_W = $clog2(LANES);

    logic                q_we;
    logic                q_wide;
    logic [ADDR_W-1:0]   q_addr;
    logic [WORD_W-1:0]   q_data;
    logic [ROW_BITS-1:0] q_row;

    // Remember the write of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_we   <= 1'b0;
            q_wide <= 1'b0;
            q_addr <= '0;
            q_data <= '0;
            q_row  <= '0;
        end else begin
            q_we   <= wr_en;
            q_wide <= wr_wide;
            q_addr <= wr_addr;
            q_data <= wr_data;
            q_row  <= wr_row;
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_a_data == '0 && rd_b_data == '0 && rd_c_data == '0 && rd_a_row == '0));

    p_narrow_write_then_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_we && !q_wide && rd_b_en && rd_b_addr == q_addr) |=> rd_b_data == $past(q_data));

    p_wide_write_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_we && q_wide && rd_a_en && rd_a_wide &&
         rd_a_addr[ADDR_W-1:LANE_W] == q_addr[ADDR_W-1:LANE_W]) |=> rd_a_row == $past(q_row));

    p_wide_read_keeps_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_en && rd_a_wide) |=> $stable(rd_a_data));

    p_idle_port_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_c_en |=> $stable(rd_c_data));

    p_ports_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_en && rd_c_en && rd_b_addr == rd_c_addr) |=> rd_b_data == rd_c_data);

endmodule

bind wide_regfile wide_regfile_checker #(
    .WORD_W (WORD_W), .LANES (LANES), .ROWS (ROWS), .ADDR_W (ADDR_W), .ROW_BITS (ROW_BITS)
) u_checker (
    .clk (clk), .rst_n (rst_n),
    .rd_a_en (rd_a_en), .rd_a_wide (rd_a_wide), .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data), .rd_a_row (rd_a_row),
    .rd_b_en (rd_b_en), .rd_b_addr (rd_b_addr), .rd_b_data (rd_b_data),
    .rd_c_en (rd_c_en), .rd_c_addr (rd_c_addr), .rd_c_data (rd_c_data),
    .wr_en (wr_en), .wr_wide (wr_wide), .wr_addr (wr_addr),
    .wr_data (wr_data), .wr_row (wr_row)
);

// File: tb/wide_regfile_test.sv
// Bench for wide_regfile: sweeps all words and groups against an arithmetic shadow model.
module wide_regfile_test;

    localparam int W = 32;
    localparam int N = 512;
    localparam int G = 64;
    localparam int RB = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_a_en = 1'b0, rd_a_wide = 1'b0;
    logic [8:0]    rd_a_addr = '0;
    logic [W-1:0]  rd_a_data;
    logic [RB-1:0] rd_a_row;
    logic          rd_b_en = 1'b0;
    logic [8:0]    rd_b_addr = '0;
    logic [W-1:0]  rd_b_data;
    logic          rd_c_en = 1'b0;
    logic [8:0]    rd_c_addr = '0;
    logic [W-1:0]  rd_c_data;
    logic          wr_en = 1'b0, wr_wide = 1'b0;
    logic [8:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [RB-1:0] wr_row = '0;

    logic [W-1:0] model [N];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wide_regfile uut (
        .clk (clk), .rst_n (rst_n),
        .rd_a_en (rd_a_en), .rd_a_wide (rd_a_wide), .rd_a_addr (rd_a_addr),
        .rd_a_data (rd_a_data), .rd_a_row (rd_a_row),
        .rd_b_en (rd_b_en), .rd_b_addr (rd_b_addr), .rd_b_data (rd_b_data),
        .rd_c_en (rd_c_en), .rd_c_addr (rd_c_addr), .rd_c_data (rd_c_data),
        .wr_en (wr_en), .wr_wide (wr_wide), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_row (wr_row)
    );

    function automatic logic [W-1:0] pat(input int a, input int seed);
        return (32'h9E37_79B9 * 32'(a + 1)) ^ (32'(seed) * 32'h0101_0101) ^ 32'(a << 20);
    endfunction

    function automatic logic [RB-1:0] model_row(input int g);
        logic [RB-1:0] r;
        for (int l = 0; l < 8; l++) r[l*W +: W] = model[g*8 + l];
        return r;
    endfunction

    task automatic chk(input string req, input logic [RB-1:0] act, input logic [RB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_a_en = 0; rd_a_wide = 0; rd_b_en = 0; rd_c_en = 0; wr_en = 0; wr_wide = 0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] old_w, keep_a, keep_b;
        logic [RB-1:0] old_r, keep_row;
        // R1: outputs clear under reset
        repeat (3) @(negedge clk);
        chk("R1 reset a", {224'b0, rd_a_data}, '0);
        chk("R1 reset b", {224'b0, rd_b_data}, '0);
        chk("R1 reset c", {224'b0, rd_c_data}, '0);
        chk("R1 reset row", rd_a_row, '0);
        rst_n = 1;

        // R3: narrow fill of every word
        for (int a = 0; a < N; a++) begin
            wr_en = 1; wr_wide = 0; wr_addr = 9'(a); wr_data = pat(a, 1);
            model[a] = pat(a, 1);
            @(negedge clk);
        end
        idle();

        // R2, R8: three ports read different words each cycle
        for (int a = 0; a < N; a++) begin
            rd_a_en = 1; rd_a_addr = 9'(a);
            rd_b_en = 1; rd_b_addr = 9'((a + 171) % N);
            rd_c_en = 1; rd_c_addr = 9'((a + 342) % N);
            @(negedge clk);
            chk("R2 port a", {224'b0, rd_a_data}, {224'b0, model[a]});
            chk("R8 port b", {224'b0, rd_b_data}, {224'b0, model[(a + 171) % N]});
            chk("R8 port c", {224'b0, rd_c_data}, {224'b0, model[(a + 342) % N]});
        end
        idle();
        keep_a = rd_a_data;

        // R5: wide reads with nonzero low bits; narrow output untouched
        for (int g = 0; g < G; g++) begin
            rd_a_en = 1; rd_a_wide = 1; rd_a_addr = 9'(g * 8 + (g % 8));
            @(negedge clk);
            chk("R5 wide read row", rd_a_row, model_row(g));
            chk("R5 narrow word held", {224'b0, rd_a_data}, {224'b0, keep_a});
        end
        idle();

        // R4: wide writes of every group; wr_data and low bits are junk
        for (int g = 0; g < G; g++) begin
            wr_en = 1; wr_wide = 1; wr_addr = 9'(g * 8 + ((g * 5) % 8)); wr_data = 32'hDEAD_BEEF;
            for (int l = 0; l < 8; l++) begin
                wr_row[l*W +: W] = pat(g * 8 + l, 2);
                model[g * 8 + l] = pat(g * 8 + l, 2);
            end
            @(negedge clk);
        end
        idle();
        for (int a = 0; a < N; a++) begin
            rd_b_en = 1; rd_b_addr = 9'(a);
            @(negedge clk);
            chk("R4 wide write lane order", {224'b0, rd_b_data}, {224'b0, model[a]});
        end
        idle();
        keep_row = rd_a_row;

        // R6: narrow read on port A leaves the row register alone
        rd_a_en = 1; rd_a_wide = 0; rd_a_addr = 9'd77;
        @(negedge clk);
        chk("R6 row held on narrow read", rd_a_row, keep_row);
        idle();

        // R3: single-lane writes into a wide-written group
        for (int l = 0; l < 8; l++) begin
            wr_en = 1; wr_addr = 9'(5 * 8 + l); wr_data = pat(l, 3);
            model[5 * 8 + l] = pat(l, 3);
            @(negedge clk);
            wr_en = 0;
            rd_a_en = 1; rd_a_wide = 1; rd_a_addr = 9'(5 * 8);
            @(negedge clk);
            chk("R3 lane write only its word", rd_a_row, model_row(5));
            idle();
        end

        // R7: narrow collision returns old, then new
        for (int k = 0; k < 6; k++) begin
            int a = (k * 97 + 13) % N;
            old_w = model[a];
            wr_en = 1; wr_addr = 9'(a); wr_data = pat(a, 4);
            rd_c_en = 1; rd_c_addr = 9'(a);
            model[a] = pat(a, 4);
            @(negedge clk);
            chk("R7 narrow collision old", {224'b0, rd_c_data}, {224'b0, old_w});
            wr_en = 0;
            @(negedge clk);
            chk("R7 narrow read after", {224'b0, rd_c_data}, {224'b0, model[a]});
            idle();
        end

        // R7: wide collision returns old row, then new
        for (int k = 0; k < 4; k++) begin
            int g = (k * 17 + 3) % G;
            old_r = model_row(g);
            wr_en = 1; wr_wide = 1; wr_addr = 9'(g * 8 + 7);
            for (int l = 0; l < 8; l++) begin
                wr_row[l*W +: W] = pat(g * 8 + l, 5);
                model[g * 8 + l] = pat(g * 8 + l, 5);
            end
            rd_a_en = 1; rd_a_wide = 1; rd_a_addr = 9'(g * 8 + 2);
            @(negedge clk);
            chk("R7 wide collision old", rd_a_row, old_r);
            wr_en = 0;
            @(negedge clk);
            chk("R7 wide read after", rd_a_row, model_row(g));
            idle();
        end

        // R6: disabled ports hold while the word they showed is rewritten
        rd_b_en = 1; rd_b_addr = 9'd10;
        @(negedge clk);
        keep_b = rd_b_data;
        keep_row = rd_a_row;
        rd_b_en = 0; rd_b_addr = 9'd200;
        wr_en = 1; wr_addr = 9'd10; wr_data = 32'h1234_5678; model[10] = 32'h1234_5678;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        chk("R6 idle port b holds", {224'b0, rd_b_data}, {224'b0, keep_b});
        chk("R6 idle row holds", rd_a_row, keep_row);
        rd_b_en = 1; rd_b_addr = 9'd10;
        @(negedge clk);
        chk("R2 read after hold", {224'b0, rd_b_data}, {224'b0, 32'h1234_5678});
        idle();

        // R1: reset again after activity
        rst_n = 0;
        @(negedge clk);
        chk("R1 second reset a", {224'b0, rd_a_data}, '0);
        chk("R1 second reset b", {224'b0, rd_b_data}, '0);
        chk("R1 second reset c", {224'b0, rd_c_data}, '0);
        chk("R1 second reset row", rd_a_row, '0);
        rst_n = 1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule